// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block owns the refresh side of an SDRAM controller that drives two chip selects. An internal interval timer counts down from a programmed value. Each time it expires, the block stops granting new accesses to the access engine. It then waits for any access already running to finish. Next it drives a precharge-all to both chip selects, waits the row precharge time, and drives an auto-refresh to both chip selects in the same cycle. After that it holds off new grants for a programmed refresh-to-activate delay.

A control bit moves both devices into and out of self-refresh. Setting the bit produces a precharge-all, then a self-refresh entry with clock enable low. Clock enable stays low until the bit is cleared. Clearing it produces one exit cycle with clock enable high and a no-operation command. A recovery wait follows before accesses resume. While the devices are in self-refresh, periodic refresh is paused and no access is granted.

The access engine raises `acc_req` when it wants the bus and holds `acc_busy` while an access is in flight. It may start an activate only in a cycle where `acc_grant` is high. When this block is not issuing a command, its command pins are deselected so that the engine's commands can be merged outside.

Top module: `sdram_refresh_seq`

## Requirements
- R1: No precharge-all starts while `acc_busy` is high. The first precharge-all appears in the cycle after `acc_busy` is first sampled low with a refresh pending. `acc_grant` is low from the cycle in which a refresh becomes due until the sequence has finished.
- R2: Precharge-all is encoded as cs_n=2'b00, ras_n=0, cas_n=1, we_n=0, cke=1. Auto-refresh is encoded as cs_n=2'b00, ras_n=0, cas_n=0, we_n=1, cke=1. Both chip selects are always low together for these commands.
- R3: Exactly TRP_CYC deselected cycles (cs_n=2'b11, default 2) separate a precharge-all from the following auto-refresh or self-refresh entry.
- R4: After an auto-refresh in cycle r, `acc_grant` stays low through cycle r+max(cfg_trc,1). With `acc_req` held high and nothing else pending, it rises in cycle r+max(cfg_trc,1)+1.
- R5: Refresh requests come every cfg_interval+1 clocks. The first one comes cfg_interval+1 clocks after reset is released, and the matching precharge-all is driven in that cycle.
- R6: When `cfg_self` is sampled high and the engine is idle, the block drives precharge-all, waits TRP_CYC cycles, then drives a self-refresh entry. The entry is the auto-refresh encoding with cke=0. cke then stays low while `cfg_self` stays high.
- R7: When `cfg_self` is sampled low in self-refresh, the next cycle drives cs_n=2'b00, ras_n=cas_n=we_n=1, cke=1. `acc_grant` then stays low for max(cfg_trc,1) further cycles.
- R8: While cke is low, no auto-refresh command is issued and `acc_grant` is low. The interval timer holds its count, and it resumes counting on the exit cycle.
- R9: When nothing is pending and no sequence is running, the command pins are deselected (cs_n=2'b11, ras_n=cas_n=we_n=1, cke=1), and `acc_grant` follows `acc_req` one cycle later.
- R10: While `rst` is high, the command pins are deselected with cke=1 and `acc_grant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | IW | Refresh interval; period is value+1 clocks |
| cfg_trc | input | TW | Refresh-to-activate and self-refresh exit delay in clocks (0 acts as 1) |
| cfg_self | input | 1 | Self-refresh control bit |
| acc_req | input | 1 | Access engine requests the bus |
| acc_busy | input | 1 | Access engine has an access in flight |
| acc_grant | output | 1 | Access engine may issue an activate |
| sd_cs_n | output | NCS | Active-low chip selects |
| sd_ras_n | output | 1 | Active-low row strobe |
| sd_cas_n | output | 1 | Active-low column strobe |
| sd_we_n | output | 1 | Active-low write enable |
| sd_cke | output | 1 | Clock enable |

## Verification
The hardest situation to reach is a refresh that falls due while an access is still running, combined with the timer pausing and then resuming across a long self-refresh. Both depend on the exact cycle in which the interval count reaches zero. The stimulus therefore holds `acc_busy` high across the second expiry, so the pending refresh has to wait for it to drop. It then keeps `cfg_self` high for longer than one refresh interval. The expected cycle of each precharge, refresh, entry and exit command is computed in advance from the interval. This includes the precharge after self-refresh, which arrives only after the held count has drained.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TRP, S_REF, S_TRC, S_SRE, S_SELF, S_SRX, S_XWAIT
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cke;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = 5'b1_1111;

  function automatic sd_cmd_t cmd_for(seq_state_t s);
    sd_cmd_t c;
    c = CMD_DESEL;
    case (s)
      S_PRE:  c = 5'b0_0101;  // precharge all
      S_REF:  c = 5'b0_0011;  // auto refresh
      S_SRE:  c = 5'b0_0010;  // refresh with clock enable low
      S_SELF: c = 5'b1_1110;  // deselect, clock enable held low
      S_SRX:  c = 5'b0_1111;  // nop with clock enable raised
      default: c = CMD_DESEL;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [IW-1:0] reload_val,
  output logic          tick
);
  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= reload_val;
    end else if (en) begin
      if (cnt == '0) cnt <= reload_val;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tick = en && (cnt == '0);
endmodule

// File: rtl/ref_wait_cnt.sv
module ref_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdram_ref_pkg::*;
#(
  parameter int IW      = 16,
  parameter int TW      = 4,
  parameter int TRP_CYC = 2,
  parameter int NCS     = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IW-1:0]  cfg_interval,
  input  logic [TW-1:0]  cfg_trc,
  input  logic           cfg_self,
  input  logic           acc_req,
  input  logic           acc_busy,
  output logic           acc_grant,
  output logic [NCS-1:0] sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic           sd_cke
);
  localparam int TPW = (TRP_CYC > 1) ? $clog2(TRP_CYC) : 1;
  localparam int WW  = (TW > TPW) ? TW : TPW;
  localparam int SW  = 8;

  seq_state_t st, st_nxt;
  logic       sr_path, ref_pend, pend_nxt, tick, in_sr;
  logic       wait_done, wait_load;
  logic [WW-1:0] wait_val;
  logic [TW-1:0] trc_m1;
  sd_cmd_t    cmd_q;
  logic       grant_q;

  assign in_sr  = (st == S_SRE) || (st == S_SELF);
  assign trc_m1 = (cfg_trc == '0) ? '0 : cfg_trc - 1'b1;

  ref_interval_timer #(.IW(IW)) u_timer (
    .clk(clk), .rst(rst), .en(!in_sr), .reload_val(cfg_interval), .tick(tick)
  );

  always_comb begin
    st_nxt = st;
    case (st)
      S_IDLE:  if (!acc_busy && (cfg_self || ref_pend || tick)) st_nxt = S_PRE;
      S_PRE:   st_nxt = S_TRP;
      S_TRP:   if (wait_done) st_nxt = sr_path ? S_SRE : S_REF;
      S_REF:   st_nxt = S_TRC;
      S_TRC:   if (wait_done) st_nxt = S_IDLE;
      S_SRE:   st_nxt = S_SELF;
      S_SELF:  if (!cfg_self) st_nxt = S_SRX;
      S_SRX:   st_nxt = S_XWAIT;
      S_XWAIT: if (wait_done) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  assign wait_load = (st_nxt != st) &&
                     (st_nxt == S_TRP || st_nxt == S_TRC || st_nxt == S_XWAIT);
  assign wait_val  = (st_nxt == S_TRP) ? WW'(TRP_CYC - 1) : WW'(trc_m1);

  ref_wait_cnt #(.W(WW)) u_wait (
    .clk(clk), .rst(rst), .load(wait_load), .val(wait_val), .done(wait_done)
  );

  always_comb begin
    if (tick)
      pend_nxt = 1'b1;
    else if ((st_nxt != st) && (st_nxt == S_REF || st_nxt == S_SRE))
      pend_nxt = 1'b0;
    else
      pend_nxt = ref_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      sr_path  <= 1'b0;
      ref_pend <= 1'b0;
      cmd_q    <= CMD_DESEL;
      grant_q  <= 1'b0;
    end else begin
      st       <= st_nxt;
      ref_pend <= pend_nxt;
      if (st == S_IDLE && st_nxt == S_PRE) sr_path <= cfg_self;
      cmd_q    <= cmd_for(st_nxt);
      grant_q  <= (st_nxt == S_IDLE) && acc_req && !pend_nxt && !cfg_self;
    end
  end

  assign sd_cs_n   = {NCS{cmd_q.cs_n}};
  assign sd_ras_n  = cmd_q.ras_n;
  assign sd_cas_n  = cmd_q.cas_n;
  assign sd_we_n   = cmd_q.we_n;
  assign sd_cke    = cmd_q.cke;
  assign acc_grant = grant_q;

  // ---------------- assertions ----------------
  logic          pre_cmd, ref_like;
  logic [SW-1:0] since_pre, since_ref;
  logic [TW-1:0] trc_at_ref;
  logic          ref_seen;

  assign pre_cmd  = (sd_cs_n == '0) && !sd_ras_n && sd_cas_n && !sd_we_n;
  assign ref_like = (sd_cs_n == '0) && !sd_ras_n && !sd_cas_n && sd_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pre  <= '1;
      since_ref  <= '1;
      trc_at_ref <= '0;
      ref_seen   <= 1'b0;
    end else begin
      since_pre <= pre_cmd ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
      if (ref_like && sd_cke) begin
        since_ref  <= SW'(1);
        trc_at_ref <= cfg_trc;
        ref_seen   <= 1'b1;
      end else if (since_ref != '1) begin
        since_ref <= since_ref + 1'b1;
      end
    end
  end

  assert_pre_after_idle_R1: assert property (@(posedge clk) disable iff (rst)
    pre_cmd |-> !$past(acc_busy));

  assert_grant_not_in_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> (sd_cs_n == '1));

  assert_both_cs_R2: assert property (@(posedge clk) disable iff (rst)
    !sd_ras_n |-> (sd_cs_n == '0));

  assert_trp_gap_R3: assert property (@(posedge clk) disable iff (rst)
    ref_like |-> (since_pre == SW'(TRP_CYC + 1)));

  assert_trc_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_grant && ref_seen) |-> ((since_ref > SW'(trc_at_ref)) && (since_ref >= SW'(2))));

  assert_exit_nop_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_cke) |-> ((sd_cs_n == '0) && sd_ras_n && sd_cas_n && sd_we_n));

  assert_quiet_in_self_R8: assert property (@(posedge clk) disable iff (rst)
    !sd_cke |-> (!acc_grant && !(ref_like && $past(!sd_cke))));

endmodule

// File: tb/test_sdram_refresh_seq.sv
module test_sdram_refresh_seq;
  localparam int CLK_P = 10;
  localparam int IW = 16, TW = 4, NCS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] cfg_interval = 16'd40;
  logic [TW-1:0] cfg_trc = 4'd6;
  logic cfg_self = 1'b0, acc_req = 1'b1, acc_busy = 1'b0;
  logic acc_grant;
  logic [NCS-1:0] sd_cs_n;
  logic sd_ras_n, sd_cas_n, sd_we_n, sd_cke;

  sdram_refresh_seq #(.IW(IW), .TW(TW), .TRP_CYC(2), .NCS(NCS)) i_sdram_refresh_seq (
    .clk(clk), .rst(rst), .cfg_interval(cfg_interval), .cfg_trc(cfg_trc),
    .cfg_self(cfg_self), .acc_req(acc_req), .acc_busy(acc_busy),
    .acc_grant(acc_grant), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_cke(sd_cke)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  int p0 = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // event codes: 1 precharge-all, 2 auto-refresh, 3 self-refresh entry, 4 exit nop, 9 other
  typedef struct { int at; int code; string req; } ev_t;
  ev_t exp_q[$];
  ev_t cur;

  task automatic expect_ev(int rel, int code, string req);
    ev_t e;
    e.at = p0 + rel; e.code = code; e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic int classify();
    if (sd_cs_n == 2'b00 && !sd_ras_n && sd_cas_n && !sd_we_n && sd_cke) return 1;
    if (sd_cs_n == 2'b00 && !sd_ras_n && !sd_cas_n && sd_we_n && sd_cke) return 2;
    if (sd_cs_n == 2'b00 && !sd_ras_n && !sd_cas_n && sd_we_n && !sd_cke) return 3;
    if (sd_cs_n == 2'b00 && sd_ras_n && sd_cas_n && sd_we_n && sd_cke) return 4;
    return 9;
  endfunction

  // monitor: every non-deselect command is compared with the scoreboard
  always @(negedge clk) begin
    if (!rst && !finished && sd_cs_n != 2'b11) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected command code %0d at cycle %0d, expected none", classify(), cyc - p0);
      end else begin
        cur = exp_q.pop_front();
        if (cur.at != cyc || cur.code != classify()) begin
          n_fail++;
          $display("FAIL %s: command code %0d at cycle %0d, expected code %0d at cycle %0d",
                   cur.req, classify(), cyc - p0, cur.code, cur.at - p0);
        end
      end
    end
  end

  task automatic wait_rel(int rel);
    do @(negedge clk); while (cyc < p0 + rel);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s = %b at cycle %0d, expected %b", req, what, act, cyc - p0, exp);
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do @(negedge clk); while (cyc < 3);
    // R10: reset state
    chk("R10", "cs_n all high", &sd_cs_n, 1'b1);
    chk("R10", "ras_n", sd_ras_n, 1'b1);
    chk("R10", "cke", sd_cke, 1'b1);
    chk("R10", "grant", acc_grant, 1'b0);
    do @(negedge clk); while (cyc < 5);
    rst = 1'b0;
    p0 = cyc;
    // R5 period 41, R3 two idle cycles, R1 busy delays second refresh
    expect_ev(41, 1, "R5");  expect_ev(44, 2, "R3");
    expect_ev(91, 1, "R1");  expect_ev(94, 2, "R3");
    expect_ev(123, 1, "R5"); expect_ev(126, 2, "R2");
    expect_ev(136, 1, "R6"); expect_ev(139, 3, "R6");
    expect_ev(200, 4, "R7");
    expect_ev(225, 1, "R8"); expect_ev(228, 2, "R8");

    wait_rel(1);   chk("R9", "grant idle", acc_grant, 1'b1);
                   chk("R9", "cs_n all high", &sd_cs_n, 1'b1);
    wait_rel(41);  chk("R1", "grant during precharge", acc_grant, 1'b0);
    wait_rel(50);  chk("R4", "grant before trc", acc_grant, 1'b0);
    wait_rel(51);  chk("R4", "grant after trc", acc_grant, 1'b1);
    wait_rel(74);  acc_busy = 1'b1;
    wait_rel(85);  chk("R1", "grant with refresh pending", acc_grant, 1'b0);
    wait_rel(90);  acc_busy = 1'b0;
    wait_rel(135); cfg_self = 1'b1;
    wait_rel(139); chk("R6", "cke at entry", sd_cke, 1'b0);
    wait_rel(170); chk("R6", "cke held", sd_cke, 1'b0);
                   chk("R8", "grant in self-refresh", acc_grant, 1'b0);
    wait_rel(199); cfg_self = 1'b0;
    wait_rel(200); chk("R7", "cke at exit", sd_cke, 1'b1);
    wait_rel(206); chk("R7", "grant in exit wait", acc_grant, 1'b0);
    wait_rel(207); chk("R7", "grant after exit wait", acc_grant, 1'b1);
    wait_rel(210); cfg_trc = 4'd0;
    wait_rel(229); chk("R4", "grant with zero trc", acc_grant, 1'b0);
    wait_rel(230); chk("R4", "grant after one-cycle trc", acc_grant, 1'b1);
    wait_rel(240);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5: %0d commands missing, expected 0", exp_q.size());
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule